// File: doc/BRIEF.md
# Dual-Rail Precharge-Evaluate Pipeline

A clocked behavioural model of a latch-free pipeline of `K` stages that carries `W`-bit words in dual-rail form. Each stage works like a bank of dynamic gates. It is either precharged, with every rail low (the spacer), or evaluating, in which case its rails can only rise towards the word offered by the stage in front. No latch and no controller sit between stages. The only thing that steers a stage is the completion flag of the stage behind it. When that flag is high, the stage precharges. When it is low, the stage evaluates. Each stage's completion flag comes from a detector with C-element behaviour: it rises once every bit of the stage has a valid rail, falls once every bit is back to spacer, and otherwise keeps its value.

The source watches `src_ack`, which is the completion flag of the first stage. It offers a word while the flag is low and returns to spacer once the flag is high. The sink sees the last stage and its completion flag. It raises `snk_ack` to let that stage precharge. Each protocol event takes one clock, so a word needs six clocks per cycle. Words always travel with at least one spacer stage between them.

Top module: `pc_eval_pipe`

## Requirements
- R1: While reset is asserted, every stage is precharged. `snk_t`, `snk_f`, `snk_done` and `src_ack` are all 0.
- R2: Bit i of a word is the rail pair (t[i], f[i]). The pair (1,0) means 1, (0,1) means 0, and (0,0) is spacer. The output never shows (1,1) on any bit.
- R3: `snk_done` becomes 1 one clock after every output bit is valid. It becomes 0 one clock after every output bit is spacer. Otherwise it keeps its value.
- R4: A stage precharges (all rails to 0 on the next clock) while the completion flag of the following stage is 1. The last stage follows `snk_ack` instead. A stage evaluates while that control is 0.
- R5: While a stage evaluates, its rails never fall. A word held at the output stays unchanged until the sink acknowledges it.
- R6: Words leave in the order they were accepted, with values unchanged. No word is lost and none is duplicated.
- R7: If the source and sink both respond within the same cycle, a new word leaves the pipeline every 6 clocks in steady state.
- R8: A word offered to an empty pipeline appears, fully valid, on `snk_t`/`snk_f` K clocks later.
- R9: If the sink never acknowledges, the pipeline accepts at most ceil(K/2) words (2 for K=4).
- R10: `src_ack` is the completion flag of the first stage. It is 0 while that stage is precharged, even when the source is offering a word that cannot be accepted yet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one protocol event per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_t | input | W | Source true rails |
| src_f | input | W | Source false rails |
| src_ack | output | 1 | Completion flag of the first stage |
| snk_t | output | W | Last-stage true rails |
| snk_f | output | W | Last-stage false rails |
| snk_done | output | 1 | Completion flag of the last stage |
| snk_ack | input | 1 | Sink acknowledge; 1 precharges the last stage |

## Verification
A word offered to an empty pipeline is due on the output after exactly K rising edges. Its completion flag follows one edge later. The bench drives the source and sink on the falling edge, and each reacts to what it sampled there, so it behaves like a same-cycle responder. It samples outputs on the falling edge too. It records the cycle at which each word is offered and at which it arrives, and checks the latency against K, the gap between arrivals against 6, and the completion flag against the one-edge lag. The stall phase holds `snk_ack` low for long enough that any further acceptance would have happened, then counts the words that went in.

// File: rtl/pc_eval_pipe.sv
module pc_eval_pipe #(
  parameter int K = 4,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_t,
  input  logic [W-1:0] src_f,
  output logic         src_ack,
  output logic [W-1:0] snk_t,
  output logic [W-1:0] snk_f,
  output logic         snk_done,
  input  logic         snk_ack
);

  for (genvar n = 0; n < K; n++) begin : stg
    logic [W-1:0] t_q, f_q;
    logic         c_q;
    logic [W-1:0] in_t, in_f;
    logic         pre;

    if (n == 0) begin : g_first
      assign in_t = src_t;
      assign in_f = src_f;
    end else begin : g_mid
      assign in_t = stg[n-1].t_q;
      assign in_f = stg[n-1].f_q;
    end

    if (n == K-1) begin : g_last
      assign pre = snk_ack;
    end else begin : g_ctl
      assign pre = stg[n+1].c_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        t_q <= '0;
        f_q <= '0;
      end else if (pre) begin
        t_q <= '0;
        f_q <= '0;
      end else begin
        t_q <= t_q | in_t;
        f_q <= f_q | in_f;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        c_q <= 1'b0;
      else if (&(t_q | f_q))
        c_q <= 1'b1;
      else if ((t_q | f_q) == '0)
        c_q <= 1'b0;
    end
  end

  assign src_ack  = stg[0].c_q;
  assign snk_t    = stg[K-1].t_q;
  assign snk_f    = stg[K-1].f_q;
  assign snk_done = stg[K-1].c_q;

endmodule

module pc_eval_pipe_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] snk_t,
  input logic [W-1:0] snk_f,
  input logic         snk_done,
  input logic         snk_ack
);

  AST_NO_DOUBLE_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (snk_t & snk_f) == '0); // R2

  AST_DONE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (&(snk_t | snk_f)) |=> snk_done); // R3

  AST_DONE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ((snk_t | snk_f) == '0) |=> !snk_done); // R3

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&(snk_t | snk_f)) && ((snk_t | snk_f) != '0)) |=> $stable(snk_done)); // R3

  AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    snk_ack |=> ((snk_t | snk_f) == '0)); // R4

  AST_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    !snk_ack |=> (((snk_t & $past(snk_t)) == $past(snk_t)) &&
                  ((snk_f & $past(snk_f)) == $past(snk_f)))); // R5

endmodule

bind pc_eval_pipe pc_eval_pipe_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .snk_t(snk_t), .snk_f(snk_f),
  .snk_done(snk_done), .snk_ack(snk_ack)
);

// File: tb/pc_eval_pipe_tb.sv
module pc_eval_pipe_tb;
  localparam int K = 4;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] src_t = '0, src_f = '0, snk_t, snk_f;
  logic src_ack, snk_done, snk_ack = 1'b0;

  pc_eval_pipe #(.K(K), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_t(src_t), .src_f(src_f), .src_ack(src_ack),
    .snk_t(snk_t), .snk_f(snk_f), .snk_done(snk_done), .snk_ack(snk_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int pend = 0, acc_cnt = 0, rcv = 0, last_arr = -1, serial = 0;
  bit showing = 0, seen = 0, done_next = 0, lat_chk = 0, per_chk = 0, stall = 0;
  logic [W-1:0] cur;
  logic [W-1:0] exp_q[$];
  int tp_q[$];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    #(CLK_PERIOD * MAX_CYC);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, MAX_CYC);
    finish_run();
  end

  // sink: same-cycle responder unless stalled
  always @(negedge clk) snk_ack = rst_n && !stall && snk_done;

  // source driver: offers words, pushes expected items when accepted
  always @(negedge clk) begin
    if (rst_n) begin
      if (showing && src_ack) begin
        exp_q.push_back(cur);
        acc_cnt++;
        src_t = '0;
        src_f = '0;
        showing = 0;
      end else if (!showing && !src_ack && pend > 0) begin
        cur = W'(8'hA5 ^ (serial * 37));
        serial++;
        src_t = cur;
        src_f = ~cur;
        showing = 1;
        pend--;
        tp_q.push_back(cyc);
      end
    end
  end

  // monitor: pops and compares at each arrival
  always @(negedge clk) begin
    if (rst_n) begin
      if (&(snk_t | snk_f)) begin
        if (!seen) begin
          seen = 1;
          rcv++;
          check(snk_done == 1'b0, "R3 done lags arrival", int'(snk_done), 0);
          check(snk_f == ~snk_t, "R2 rail pairs", int'(snk_f), int'(~snk_t));
          if (exp_q.size() == 0) begin
            check(0, "R6 duplicate word", int'(snk_t), -1);
          end else begin
            logic [W-1:0] e;
            int tp;
            e = exp_q.pop_front();
            tp = tp_q.pop_front();
            check(snk_t == e, "R6 order/value", int'(snk_t), int'(e));
            if (lat_chk) check(cyc - tp == K, "R8 latency", cyc - tp, K);
          end
          if (per_chk && last_arr >= 0)
            check(cyc - last_arr == 6, "R7 period", cyc - last_arr, 6);
          last_arr = cyc;
          done_next = 1;
        end else if (done_next) begin
          check(snk_done == 1'b1, "R3 done rises", int'(snk_done), 1);
          done_next = 0;
        end
      end else if ((snk_t | snk_f) == '0) begin
        seen = 0;
      end
    end
  end

  initial begin
    int acc0, rcv0;
    repeat (3) @(negedge clk);
    check(snk_t == '0 && snk_f == '0, "R1 spacer in reset", int'(snk_t | snk_f), 0);
    check(snk_done == 0 && src_ack == 0, "R1 flags in reset", int'({snk_done, src_ack}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // single word, empty pipe: latency
    lat_chk = 1;
    pend = 1;
    wait (rcv == 1);
    @(negedge clk);
    lat_chk = 0;
    repeat (10) @(negedge clk);

    // streaming: period
    per_chk = 1;
    last_arr = -1;
    pend = 8;
    wait (rcv == 9);
    @(negedge clk);
    per_chk = 0;
    repeat (20) @(negedge clk);

    // stalled sink: capacity and hold
    stall = 1;
    acc0 = acc_cnt;
    rcv0 = rcv;
    pend = 4;
    repeat (80) @(negedge clk);
    check(acc_cnt - acc0 == (K + 1) / 2, "R9 capacity", acc_cnt - acc0, (K + 1) / 2);
    check(rcv - rcv0 == 1, "R4/R5 held word", rcv - rcv0, 1);
    check(&(snk_t | snk_f), "R5 output still valid", int'(snk_t | snk_f), (1 << W) - 1);
    check(src_ack == 1'b0, "R10 first stage precharged", int'(src_ack), 0);
    stall = 0;
    wait (rcv == 13);
    repeat (30) @(negedge clk);
    check(rcv == 13, "R6 no loss", rcv, 13);
    check(exp_q.size() == 0, "R6 queue drained", exp_q.size(), 0);
    check(snk_t == '0 && snk_f == '0 && !snk_done, "R4 drained to spacer",
          int'(snk_t | snk_f), 0);
    finish_run();
  end
endmodule